// File: doc/BRIEF.md
# Two-Section Decade Counter

This block is a four-bit counter built from two sections, each with its own count input. The first section is a single toggle stage that drives bit 0. The second section cycles through five states and drives bits 3..1. Each section steps on a high-to-low change of its count input. Those changes are detected against a free-running system clock, so every flip-flop in the block sits on one clock. A two-bit mode input sets how the sections are linked inside the block:

- **BCD mode:** the toggle stage feeds the five-state stage, giving a 0..9 decimal count.
- **Bi-quinary mode:** the five-state stage feeds the toggle stage, giving a symmetric divide-by-ten square wave on bit 0.
- **Independent mode:** the two sections do not interact.

Two override requests act on the outputs as soon as they are asserted. Each one needs both of its inputs high. The clear request drives the count to zero. The preset request drives it to nine and wins over the clear. While either override is active, count edges are discarded. The edge history keeps tracking the inputs during an override, so releasing an override never produces a count.

Top module: `dctr_decade`

## Requirements
- R1: While the system reset `rst_n` is low, and after it is released with no count edges, `q_o` reads 0000.
- R2: The toggle section inverts `q_o[0]` on a falling edge of its count source and at no other time. For an external input, the output changes at the second rising system clock edge after the input falls, and is unchanged after the first.
- R3: The five-state section holds `q_o[3:1]` as a binary value. On each falling edge of its count source it steps 0,1,2,3,4 and then returns to 0.
- R4: The clear request is active only when `clr_a_i` and `clr_b_i` are both 1. It forces `q_o` to 0000 in the same cycle. A single clear input alone has no effect.
- R5: The preset request is active only when `set_a_i` and `set_b_i` are both 1. It forces `q_o` to 1001 in the same cycle and overrides the clear request. A single preset input alone has no effect.
- R6: Falling edges that occur while an override is active are ignored. After the override is released, the count holds the forced value until a new falling edge arrives.
- R7: With `mode_i` = 00 (BCD), `cnt_a_i` feeds the toggle section, and a fall of `q_o[0]` steps the five-state section one system clock later. Successive `cnt_a_i` falls give the 8421 sequence 0..9 and then wrap to 0.
- R8: With `mode_i` = 01 (bi-quinary), `cnt_b_i` feeds the five-state section, and a fall of `q_o[3]` toggles `q_o[0]`. Over ten `cnt_b_i` falls, `q_o[0]` is high for five and low for five.
- R9: With `mode_i` = 10, or 11 treated the same way, the sections do not interact. `cnt_a_i` toggles `q_o[0]`, and `cnt_b_i` steps `q_o[3:1]`.
- R10: In BCD mode, falls on `cnt_b_i` have no effect. In bi-quinary mode, falls on `cnt_a_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cnt_a_i | input | 1 | Count input of the toggle section |
| cnt_b_i | input | 1 | Count input of the five-state section |
| clr_a_i | input | 1 | Clear request, first leg |
| clr_b_i | input | 1 | Clear request, second leg |
| set_a_i | input | 1 | Preset-to-nine request, first leg |
| set_b_i | input | 1 | Preset-to-nine request, second leg |
| mode_i | input | 2 | Linking mode: 00 BCD, 01 bi-quinary, 10/11 independent |
| q_o | output | 4 | Count; bit 0 from the toggle section, bits 3..1 from the five-state section |

## Verification
Two kinds of events can land in the same cycle.

- **Count edge and override.** The bench drives a falling count input while clear is held, then releases clear while that fall is still in the edge history. The result is judged at the ports: the count must stay at zero before and after the release.
- **Internal ripple and an external fall.** In BCD mode the chained step of the five-state section comes one clock after bit 0 falls. The bench samples the clock in between and checks the intermediate value (0000 on the way from 1 to 2).

Random sequences of pulses, mode changes, partial and full overrides, and combined preset and clear are compared against a bench model of the count rules.

// File: rtl/dctr_pkg.sv
package dctr_pkg;

  typedef enum logic [1:0] {
    MD_BCD     = 2'b00,
    MD_BIQ     = 2'b01,
    MD_IND     = 2'b10,
    MD_IND_ALT = 2'b11
  } dctr_mode_e;

endpackage

// File: rtl/dctr_fall.sv
module dctr_fall (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic fall_o
);

  logic samp_q;
  logic hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      samp_q <= sig_i;
      hist_q <= samp_q;
    end
  end

  assign fall_o = hist_q & ~samp_q;

  // R2: a detected fall lasts exactly one system cycle
  p_fall_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);

endmodule

// File: rtl/dctr_div2.sv
module dctr_div2 (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic force_en_i,
  input  logic force_val_i,
  output logic q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= 1'b0;
    end else if (force_en_i) begin
      q_o <= force_val_i;
    end else if (tick_i) begin
      q_o <= ~q_o;
    end
  end

  // R2: without a tick or override the stage holds
  p_a_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !force_en_i) |=> $stable(q_o));

  // R2: a tick always changes the stage
  p_a_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !force_en_i) |=> (q_o != $past(q_o)));

endmodule

// File: rtl/dctr_modn.sv
module dctr_modn #(
  parameter  int unsigned N  = 5,
  localparam int unsigned BW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          force_en_i,
  input  logic [BW-1:0] force_val_i,
  output logic [BW-1:0] q_o
);

  localparam logic [BW-1:0] LAST = BW'(N - 1);

  logic [BW-1:0] q_next;

  always_comb begin
    if (q_o == LAST) q_next = '0;
    else             q_next = q_o + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= '0;
    end else if (force_en_i) begin
      q_o <= force_val_i;
    end else if (tick_i) begin
      q_o <= q_next;
    end
  end

  // R3: state never leaves 0..N-1
  p_b_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    q_o <= LAST);

  // R3: stepping from the last state wraps to zero
  p_b_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !force_en_i && q_o == LAST) |=> (q_o == '0));

  // R3: stepping from any other state moves upward
  p_b_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !force_en_i && q_o != LAST) |=> (q_o > $past(q_o)));

endmodule

// File: rtl/dctr_decade.sv
module dctr_decade
  import dctr_pkg::*;
#(
  parameter  int unsigned DIV_B = 5,
  localparam int unsigned BW    = $clog2(DIV_B),
  localparam int unsigned QW    = BW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_a_i,
  input  logic          cnt_b_i,
  input  logic          clr_a_i,
  input  logic          clr_b_i,
  input  logic          set_a_i,
  input  logic          set_b_i,
  input  logic [1:0]    mode_i,
  output logic [QW-1:0] q_o
);

  localparam logic [BW-1:0] B_TOP    = BW'(DIV_B - 1);
  localparam logic [QW-1:0] PRESET_Q = {B_TOP, 1'b1};

  logic clr_req, set_req, ovr, ovr_q, quiet;
  logic [1:0] ext_raw, ext_fall;
  logic q_a, hist_a, hist_b, fall_qa, fall_qb;
  logic [BW-1:0] q_b, force_b;
  logic tick_a, tick_b;
  dctr_mode_e md;

  assign clr_req = clr_a_i & clr_b_i;
  assign set_req = set_a_i & set_b_i;
  assign ovr     = clr_req | set_req;
  assign md      = dctr_mode_e'(mode_i);

  assign ext_raw = {cnt_b_i, cnt_a_i};

  for (genvar gi = 0; gi < 2; gi++) begin : g_edge
    dctr_fall u_fall (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_i  (ext_raw[gi]),
      .fall_o (ext_fall[gi])
    );
  end

  // history of the internal chaining sources and of the override
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q  <= 1'b0;
      hist_a <= 1'b0;
      hist_b <= 1'b0;
    end else begin
      ovr_q  <= ovr;
      hist_a <= q_a;
      hist_b <= q_b[BW-1];
    end
  end

  assign fall_qa = hist_a & ~q_a;
  assign fall_qb = hist_b & ~q_b[BW-1];
  assign quiet   = ~ovr & ~ovr_q;

  always_comb begin
    unique case (md)
      MD_BCD: begin
        tick_a = ext_fall[0];
        tick_b = fall_qa;
      end
      MD_BIQ: begin
        tick_a = fall_qb;
        tick_b = ext_fall[1];
      end
      MD_IND, MD_IND_ALT: begin
        tick_a = ext_fall[0];
        tick_b = ext_fall[1];
      end
      default: begin
        tick_a = 1'b0;
        tick_b = 1'b0;
      end
    endcase
  end

  assign force_b = set_req ? B_TOP : '0;

  dctr_div2 u_sec_a (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_a & quiet),
    .force_en_i  (ovr),
    .force_val_i (set_req),
    .q_o         (q_a)
  );

  dctr_modn #(.N(DIV_B)) u_sec_b (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick_b & quiet),
    .force_en_i  (ovr),
    .force_val_i (force_b),
    .q_o         (q_b)
  );

  always_comb begin
    if (set_req)      q_o = PRESET_Q;
    else if (clr_req) q_o = '0;
    else              q_o = {q_b, q_a};
  end

  // R5: preset wins and shows at once
  p_set_nine_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_a_i && set_b_i) |-> (q_o == PRESET_Q));

  // R4: clear without preset shows zero at once
  p_clr_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_a_i && clr_b_i && !(set_a_i && set_b_i)) |-> (q_o == '0));

  // R6: the cycle after release never counts
  p_release_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && !ovr) |=> (ovr || $stable(q_o)));

endmodule

// File: tb/dctr_decade_tb_top.sv
`timescale 1ns/100ps
module dctr_decade_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_a = 1'b1, cnt_b = 1'b1;
  logic clr_a = 1'b0, clr_b = 1'b0, set_a = 1'b0, set_b = 1'b0;
  logic [1:0] mode = 2'b10;
  logic [3:0] q;
  logic [3:0] exp_q;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dctr_decade dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_a_i (cnt_a),
    .cnt_b_i (cnt_b),
    .clr_a_i (clr_a),
    .clr_b_i (clr_b),
    .set_a_i (set_a),
    .set_b_i (set_b),
    .mode_i  (mode),
    .q_o     (q)
  );

  task automatic chk(input logic [3:0] exp, input string req);
    #0.2;
    n_cmp++;
    if (q !== exp) begin
      n_bad++;
      $display("FAIL %s: q=%b expected %b", req, q, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // count rules as stated in R3, R7, R8, R9, R10; src 0 = cnt_a, 1 = cnt_b
  function automatic logic [3:0] mstep(input logic [1:0] md, input logic [3:0] v, input bit src);
    logic a;
    logic [2:0] b, bn;
    a = v[0];
    b = v[3:1];
    bn = (b == 3'd4) ? 3'd0 : b + 3'd1;
    case (md)
      2'b00: if (!src) begin if (a) b = bn; a = ~a; end
      2'b01: if (src) begin if (b == 3'd4) a = ~a; b = bn; end
      default: if (!src) a = ~a; else b = bn;
    endcase
    return {b, a};
  endfunction

  task automatic pulse(input bit src);
    if (src) cnt_b = 1'b0; else cnt_a = 1'b0;
    clks(4);
    if (src) cnt_b = 1'b1; else cnt_a = 1'b1;
    clks(2);
  endtask

  task automatic step_chk(input bit src, input string req);
    pulse(src);
    exp_q = mstep(mode, exp_q, src);
    chk(exp_q, req);
  endtask

  task automatic do_override(input bit c, input bit s, input string req);
    clr_a = c; clr_b = c; set_a = s; set_b = s;
    if (s) exp_q = 4'b1001;
    else if (c) exp_q = 4'b0000;
    chk(exp_q, req);
    clks(2);
    clr_a = 0; clr_b = 0; set_a = 0; set_b = 0;
    clks(2);
    chk(exp_q, req);
  endtask

  initial begin
    #750000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: q=%b expected progress", q);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20241));
    clks(3);
    chk(4'b0000, "R1 in reset");
    rst_n = 1'b1;
    clks(3);
    exp_q = 4'b0000;
    chk(exp_q, "R1 after reset");

    // R9 independent mode, R2 and R3
    mode = 2'b10;
    step_chk(1'b0, "R2 toggle");
    for (int i = 0; i < 6; i++) step_chk(1'b1, "R3 five-step");
    // R2 latency
    cnt_a = 1'b0;
    clks(1);
    chk(exp_q, "R2 no change after one edge");
    clks(1);
    exp_q = mstep(mode, exp_q, 1'b0);
    chk(exp_q, "R2 change after two edges");
    cnt_a = 1'b1;
    clks(3);
    chk(exp_q, "R2 rising ignored");

    // R9 alternate code 11: b wraps without touching a
    mode = 2'b11;
    do_override(1'b1, 1'b0, "R4 clear");
    for (int i = 0; i < 5; i++) step_chk(1'b1, "R9 mode 11 b");
    chk(4'b0000, "R9 no carry into a");
    step_chk(1'b0, "R9 mode 11 a");
    step_chk(1'b0, "R9 a fall no carry");
    chk(4'b0000, "R9 a fall no carry value");

    // R7 BCD
    mode = 2'b00;
    for (int i = 0; i < 10; i++) step_chk(1'b0, "R7 bcd seq");
    chk(4'b0000, "R7 bcd wrap");
    step_chk(1'b0, "R7 bcd to 1");
    cnt_a = 1'b0;
    clks(2);
    chk(4'b0000, "R7 ripple midpoint");
    clks(1);
    chk(4'b0010, "R7 ripple result");
    cnt_a = 1'b1;
    clks(3);
    exp_q = 4'b0010;
    step_chk(1'b1, "R10 bcd ignores cnt_b");
    chk(4'b0010, "R10 bcd value kept");

    // R8 bi-quinary
    mode = 2'b01;
    do_override(1'b1, 1'b0, "R4 clear before biq");
    for (int i = 0; i < 10; i++) begin
      step_chk(1'b1, "R8 biq seq");
      if (i == 4) chk(4'b0001, "R8 q0 high at half");
    end
    chk(4'b0000, "R8 full period");
    step_chk(1'b0, "R10 biq ignores cnt_a");

    // R4, R5 partial and combined requests
    mode = 2'b10;
    step_chk(1'b1, "R4 setup");
    clr_a = 1'b1; chk(exp_q, "R4 clr_a alone"); clks(2); chk(exp_q, "R4 clr_a alone held");
    clr_a = 1'b0; clr_b = 1'b1; chk(exp_q, "R4 clr_b alone"); clr_b = 1'b0;
    set_a = 1'b1; chk(exp_q, "R5 set_a alone"); set_a = 1'b0;
    set_b = 1'b1; clks(2); chk(exp_q, "R5 set_b alone"); set_b = 1'b0;
    do_override(1'b1, 1'b1, "R5 preset beats clear");
    do_override(1'b0, 1'b1, "R5 preset");

    // R6 edge during override
    clr_a = 1'b1; clr_b = 1'b1;
    clks(1);
    cnt_a = 1'b0; cnt_b = 1'b0;
    clks(1);
    clr_a = 1'b0; clr_b = 1'b0;
    exp_q = 4'b0000;
    chk(exp_q, "R6 release");
    clks(4);
    chk(exp_q, "R6 no count after release");
    cnt_a = 1'b1; cnt_b = 1'b1;
    clks(3);
    chk(exp_q, "R6 rising after release");

    // random mix
    for (int k = 0; k < 300; k++) begin
      int op;
      op = $urandom_range(0, 7);
      case (op)
        0: mode = 2'($urandom_range(0, 3));
        1, 2: step_chk(1'b0, "R7 R8 R9 random cnt_a");
        3, 4: step_chk(1'b1, "R7 R8 R9 random cnt_b");
        5: do_override(1'b1, 1'($urandom_range(0, 1)), "R4 R5 random override");
        6: do_override(1'b0, 1'b1, "R5 random preset");
        default: begin
          if ($urandom_range(0, 1) == 0) clr_a = 1'b1; else set_b = 1'b1;
          clks(2);
          chk(exp_q, "R4 R5 random single leg");
          clr_a = 1'b0; set_b = 1'b0;
          clks(1);
        end
      endcase
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule